// File: doc/BRIEF.md
# Two-Device Chained Potentiometer Frame Packer

This block sits on the master side of a serial link to two wiper-control devices wired in a chain. The first device's data output feeds the second device's data input. Each device takes a 10-bit word: a 2-bit channel address followed by an 8-bit wiper value. A device acts on whatever 10 bits sit in its slice of the combined shift register when chip select goes high.

A command carries one channel address, the value for the device nearest the master and the value for the device at the far end. The block packs them into a 24-bit frame and sends it as three octets, most significant bit first, in SPI mode 0. The serial clock is the system clock divided by four. Four zero bits lead the frame, so the 20 significant bits are the last ones clocked. The far device's word goes out before the near device's word. When the last octet is done, chip select returns high. The block then enforces an idle gap before it will accept the next command.

Top module: `chain_frame_packer`

## Requirements
- R1: While reset is asserted and right after it, `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0 and `cmd_ready` is 1.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. On that same edge `spi_cs_n` goes to 0. `cmd_ready` stays 0 for as long as `spi_cs_n` is 0.
- R3: Each frame has exactly 24 rising edges of `spi_sclk`. Consecutive rising edges are 4 system clocks apart, with 2 clocks high and 2 clocks low.
- R4: The bits sampled on rising `spi_sclk` form the frame in this order, first to last: 4 zero pad bits, `cmd_addr[1:0]`, `cmd_far[7:0]`, `cmd_addr[1:0]`, `cmd_near[7:0]`. Each field is sent MSB first.
- R5: Model the two devices as one 20-bit chain shifted by the frame. The near device then holds {addr, near} in the last 10 bits sent, and the far device holds {addr, far} in the 10 bits before them.
- R6: `spi_mosi` changes only while `spi_sclk` is low. The first frame bit is already on `spi_mosi` in the cycle in which `spi_cs_n` falls.
- R7: `spi_sclk` is 0 whenever `spi_cs_n` is 1.
- R8: `spi_cs_n` rises 2 system clocks (half an SCLK period) after the last rising edge of `spi_sclk`. It then stays high for at least 4 system clocks before the next frame begins.
- R9: `cmd_valid` and the command fields are ignored while a frame or its idle gap is in progress. The frame that is being sent is not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_addr | input | 2 | Channel address sent to both devices |
| cmd_near | input | 8 | Wiper value for the device nearest the master |
| cmd_far | input | 8 | Wiper value for the device at the far end of the chain |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the first device |
| spi_cs_n | output | 1 | Active-low chip select shared by both devices |

## Verification
The bench uses the default parameters: 2-bit address, 8-bit values, 4 pad bits, 2 system clocks per SCLK half period and a 4-clock gap. This keeps a frame at about 100 cycles. Every address is therefore swept against sixteen arithmetically spread value pairs, plus all-zero, all-one and single-bit corners, and each frame is checked bit by bit against a software model of the two-device chain. One frame in four also offers a conflicting command while busy, which exercises the ignore rule at the ports.

// File: rtl/chain_frame_packer.sv
module chain_frame_packer #(
  parameter int ADR_W   = 2,
  parameter int VAL_W   = 8,
  parameter int PAD_W   = 4,
  parameter int HALF    = 2,
  parameter int GAP_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [ADR_W-1:0] cmd_addr,
  input  logic [VAL_W-1:0] cmd_near,
  input  logic [VAL_W-1:0] cmd_far,
  output logic             spi_sclk,
  output logic             spi_mosi,
  output logic             spi_cs_n
);
  localparam int WORD_W  = ADR_W + VAL_W;
  localparam int FRAME_W = PAD_W + 2 * WORD_W;
  localparam int PH_W    = (2 * HALF > 1) ? $clog2(2 * HALF) : 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} state_t;

  state_t             st;
  logic [FRAME_W-1:0] sr;
  logic [PH_W-1:0]    ph;
  logic [CNT_W-1:0]   bitn;
  logic [GAP_W-1:0]   gap;

  assign cmd_ready = (st == S_IDLE);
  assign spi_mosi  = sr[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sr       <= '0;
      ph       <= '0;
      bitn     <= '0;
      gap      <= '0;
      spi_sclk <= 1'b0;
      spi_cs_n <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          sr       <= {{PAD_W{1'b0}}, cmd_addr, cmd_far, cmd_addr, cmd_near};
          spi_cs_n <= 1'b0;
          ph       <= '0;
          bitn     <= '0;
          st       <= S_SHIFT;
        end
        S_SHIFT: begin
          ph <= ph + 1'b1;
          if (ph == PH_W'(HALF - 1)) spi_sclk <= 1'b1;
          if (ph == PH_W'(2 * HALF - 1)) begin
            spi_sclk <= 1'b0;
            ph       <= '0;
            if (bitn == CNT_W'(FRAME_W - 1)) begin
              spi_cs_n <= 1'b1;
              sr       <= '0;
              gap      <= '0;
              st       <= S_GAP;
            end else begin
              sr   <= sr << 1;
              bitn <= bitn + 1'b1;
            end
          end
        end
        S_GAP: begin
          gap <= gap + 1'b1;
          if (gap == GAP_W'(GAP_CYC - 1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic             sclk_q;
  logic [CNT_W:0]   rises;
  logic [GAP_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      rises  <= '0;
      hi_cnt <= GAP_W'(GAP_CYC);
    end else begin
      sclk_q <= spi_sclk;
      if (cmd_valid && cmd_ready) rises <= '0;
      else if (spi_sclk && !sclk_q) rises <= rises + 1'b1;
      if (!spi_cs_n) hi_cnt <= '0;
      else if (hi_cnt < GAP_W'(GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !cmd_ready);
  p_sclk_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  p_mosi_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));
  p_edge_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (rises == (CNT_W+1)'(FRAME_W)));
  p_gap_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |-> (hi_cnt >= GAP_W'(GAP_CYC)));
endmodule

// File: tb/chain_frame_packer_tb_top.sv
`timescale 1ns/1ps
module chain_frame_packer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_addr = '0;
  logic [7:0] cmd_near = '0;
  logic [7:0] cmd_far = '0;
  logic       spi_sclk, spi_mosi, spi_cs_n;

  always #10 clk = ~clk;

  chain_frame_packer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_near(cmd_near), .cmd_far(cmd_far),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [23:0] exp_frame = '0;
  logic [1:0]  exp_addr = '0;
  logic [7:0]  exp_near = '0, exp_far = '0;
  int          frames_done = 0;

  int cyc = 0;
  int last_rise = 0;
  int cs_rise_at = -100;
  int nr = 0;
  logic [23:0] cap = '0;
  logic p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!spi_cs_n && p_cs) begin
        chk(cyc - cs_rise_at >= 4, "R8 gap", cyc - cs_rise_at, 4);
        chk(spi_mosi == exp_frame[23], "R6 first bit", spi_mosi, exp_frame[23]);
        cap = '0;
        nr = 0;
      end
      if (!spi_cs_n && spi_sclk && !p_sclk) begin
        if (nr > 0) chk(cyc - last_rise == 4, "R3 period", cyc - last_rise, 4);
        cap = {cap[22:0], spi_mosi};
        nr++;
        last_rise = cyc;
      end
      if (spi_sclk && spi_mosi !== p_mosi)
        chk(1'b0, "R6 mosi moved while sclk high", spi_mosi, p_mosi);
      if (spi_cs_n && spi_sclk)
        chk(1'b0, "R7 sclk high with cs high", spi_sclk, 0);
      if (!spi_cs_n && cmd_ready)
        chk(1'b0, "R2 ready during frame", cmd_ready, 0);
      if (spi_cs_n && !p_cs) begin
        chk(nr == 24, "R3 edge count", nr, 24);
        chk(cap == exp_frame, "R4 frame", cap, exp_frame);
        chk(cap[23:20] == 4'h0, "R4 pad", cap[23:20], 0);
        chk(cap[9:0] == {exp_addr, exp_near}, "R5 near word", cap[9:0], {exp_addr, exp_near});
        chk(cap[19:10] == {exp_addr, exp_far}, "R5 far word", cap[19:10], {exp_addr, exp_far});
        chk(cyc - last_rise == 2, "R8 cs rise delay", cyc - last_rise, 2);
        cs_rise_at = cyc;
        frames_done++;
      end
      p_sclk = spi_sclk;
      p_cs = spi_cs_n;
      p_mosi = spi_mosi;
    end
  end

  task automatic send(input logic [1:0] a, input logic [7:0] n, input logic [7:0] f, input bit noise);
    while (!cmd_ready) @(negedge clk);
    exp_addr = a;
    exp_near = n;
    exp_far = f;
    exp_frame = {4'h0, a, f, a, n};
    cmd_addr = a;
    cmd_near = n;
    cmd_far = f;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(spi_cs_n == 1'b0, "R2 cs falls on accept", spi_cs_n, 0);
    chk(cmd_ready == 1'b0, "R2 ready low after accept", cmd_ready, 0);
    if (noise) begin
      repeat (10) @(negedge clk);
      cmd_addr = ~a;
      cmd_near = ~n;
      cmd_far = ~f;
      cmd_valid = 1'b1;
      repeat (20) @(negedge clk);
      cmd_valid = 1'b0;
      chk(spi_cs_n == 1'b0, "R9 frame still running", spi_cs_n, 0);
    end
    while (!cmd_ready) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R1 sclk", spi_sclk, 0);
    chk(spi_mosi == 1'b0, "R1 mosi", spi_mosi, 0);
    chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1 && cmd_ready == 1'b1, "R1 after release", {spi_cs_n, cmd_ready}, 3);

    send(2'd0, 8'h00, 8'h00, 1'b0);
    send(2'd3, 8'hFF, 8'hFF, 1'b0);
    send(2'd1, 8'h01, 8'h80, 1'b1);
    send(2'd2, 8'h80, 8'h01, 1'b0);
    for (int a = 0; a < 4; a++) begin
      for (int k = 0; k < 16; k++) begin
        send(2'(a), 8'((k * 37 + a * 11) & 255), 8'((k * 91 + 200 - a * 3) & 255), (k % 4) == 0);
      end
    end
    repeat (8) @(negedge clk);
    chk(frames_done == 68, "R2 frame count", frames_done, 68);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R7 idle after run", {spi_cs_n, spi_sclk}, 2);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule